// File: doc/BRIEF.md
# Programmable Watchdog Timer with Selectable Tick

This block is a watchdog peripheral on a simple word-addressed register bus. Software sets a tick resolution and turns the device on in a configuration word. It loads a 16-bit timeout, counted in ticks, into a count word. It then starts the timer through a control word and refreshes it at intervals. A refresh is a write of the self-clearing reload bit, which copies the programmed count into the down-counter and restarts the tick phase.

If software stops refreshing and the counter runs out, the block sets a sticky expiry flag. It then pulses, for one clock, either a system-reset request or a shutdown request, depending on an action bit in the control word. After that the counter halts until the next reload. A reset-cause flag records that the watchdog requested a reset. This flag is cleared only by the power-on reset, so software can still read it after the functional reset that the watchdog itself caused.

The tick comes from a prescaler that divides the block clock. There are four divide ratios, one for each resolution code, and each is a parameter.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset the control word (offset 0x0) reads 0x08, the count word (0x4) reads 0x0000FFFF, the configuration word (0x8) reads 0x01 and the status word (0xC) reads 0. The counter is halted.
- R2: Configuration bits 2:1 select the tick period. Code 0 gives DIV_R0 clocks, code 1 gives DIV_R1, code 2 gives DIV_R2 and code 3 gives DIV_R3.
- R3: Take a control write with bit 0 (run) and bit 7 (reload) set, a programmed count N and a tick period L. The expiry request is high on exactly the rising edge numbered max(N,1)*L+1 after the edge that accepts the write, and it stays high for exactly one clock. A count of 0 behaves like a count of 1.
- R4: A reload written during a countdown restarts the whole timeout, measured from that write.
- R5: The reload bit (7) and the reserved bits 6:4 of the control word read as 0. Only the low 16 bits of the count word are stored; the upper bits read as 0.
- R6: Control bit 1 (fired) becomes 1 on the clock after the expiry request. A control write with bit 1 clear leaves it at 1, and a control write with bit 1 set clears it.
- R7: Control bit 2 picks the expiry action. With 0, the block pulses rst_req. With 1, it pulses off_req, and the reset-cause flag is not set.
- R8: Configuration bit 0 disables the device, and control bit 3 reads back its value. While the device is disabled, a control write cannot set run, and setting bit 0 clears run. A disabled device never issues a request.
- R9: Clearing run freezes the remaining count. Setting run again, without a reload, resumes from that count with a fresh tick phase.
- R10: After an expiry the counter stays halted and issues no further request until it is reloaded.
- R11: Status bit 1 (reset cause) is set by a reset-action expiry. It keeps its value through rst_n and is cleared only by por_n.
- R12: After reset, setting run without any reload starts no countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and reference for the tick prescaler |
| rst_n | input | 1 | Synchronous active-low functional reset |
| por_n | input | 1 | Synchronous active-low power-on reset, which also clears the reset cause |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of a register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, decoded combinationally from bus_addr |
| rst_req | output | 1 | One-clock system-reset request on expiry |
| off_req | output | 1 | One-clock shutdown request on expiry |

## Verification
A write takes effect on the rising edge that accepts it, and readback is combinational, so every register check is made half a cycle after that edge. The expiry request is due max(N,1)*L+1 edges after the edge of the reload write. The bench computes this figure from its own divisor values. It samples one edge early to confirm the request is still low, samples on the due edge to see the pulse, and samples one edge later to confirm the pulse has ended. The fired flag is read back on the edge of the pulse and on the edge after it. For the freeze, halt and disable cases, the bench watches the request outputs at every falling edge over a fixed window and counts any pulse.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg
// Shared register offsets and bit positions for the watchdog block.
// Assumes a byte-addressed bus with 32-bit words at 4-byte steps.
package wdt_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'hC;

    // Control word bit positions
    localparam int CB_RUN    = 0;
    localparam int CB_FIRED  = 1;
    localparam int CB_ACTION = 2;
    localparam int CB_DIS    = 3;
    localparam int CB_RELOAD = 7;

    // Configuration word bit positions
    localparam int GB_DIS    = 0;
    localparam int GB_RES_LO = 1;

    // Status word bit position
    localparam int SB_CAUSE  = 1;

    typedef enum logic [1:0] {
        RES_FINE   = 2'd0,
        RES_SHORT  = 2'd1,
        RES_MEDIUM = 2'd2,
        RES_LONG   = 2'd3
    } res_sel_e;
endpackage

// File: rtl/wdt_prescaler.sv
// Module wdt_prescaler
// Produces a one-clock tick every DIV_Rx clocks. The divisor is picked
// by the resolution code. A clear input holds the phase at zero.
// Assumes every divisor is at least 1.
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int DIV_R0 = 32,
    parameter int DIV_R1 = 10000,
    parameter int DIV_R2 = 100000,
    parameter int DIV_R3 = 1000000
) (
    input  logic     clk,
    input  logic     srst_n,
    input  logic     clr,
    input  res_sel_e sel,
    output logic     tick
);
    localparam int DMAX01 = (DIV_R0 > DIV_R1) ? DIV_R0 : DIV_R1;
    localparam int DMAX23 = (DIV_R2 > DIV_R3) ? DIV_R2 : DIV_R3;
    localparam int DMAX   = (DMAX01 > DMAX23) ? DMAX01 : DMAX23;
    localparam int PW     = $clog2(DMAX + 1);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] last_v;

    // Choose the terminal phase value for the selected resolution
    always_comb begin
        unique case (sel)
            RES_FINE:   last_v = PW'(DIV_R0 - 1);
            RES_SHORT:  last_v = PW'(DIV_R1 - 1);
            RES_MEDIUM: last_v = PW'(DIV_R2 - 1);
            default:    last_v = PW'(DIV_R3 - 1);
        endcase
    end

    // Advance the phase and emit a registered tick at the terminal value
    always_ff @(posedge clk) begin
        if (!srst_n || clr) begin
            phase_q <= '0;
            tick    <= 1'b0;
        end else if (phase_q >= last_v) begin
            phase_q <= '0;
            tick    <= 1'b1;
        end else begin
            phase_q <= phase_q + 1'b1;
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_downcount.sv
// Module wdt_downcount
// Holds the remaining timeout. A reload copies the preset in and arms
// the counter. On a tick while enabled, the count drops by one. The
// tick that reaches zero raises a one-clock expiry and halts the counter.
// Assumes reload has priority over a tick in the same clock.
module wdt_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] preset,
    input  logic             count_en,
    input  logic             tick,
    output logic             expire,
    output logic             halted
);
    logic [CNT_W-1:0] remain_q;

    // Load, decrement and expiry detection
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            remain_q <= '0;
            halted   <= 1'b1;
            expire   <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (reload) begin
                remain_q <= preset;
                halted   <= 1'b0;
            end else if (count_en && !halted && tick) begin
                if (remain_q <= CNT_W'(1)) begin
                    remain_q <= '0;
                    halted   <= 1'b1;
                    expire   <= 1'b1;
                end else begin
                    remain_q <= remain_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdt_regs.sv
// Module wdt_regs
// Register file: control, count, configuration and status words,
// write decoding, the reload pulse and combinational readback.
// Assumes at most one write per clock and a word-aligned address.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire,
    input  logic              rst_pulse,
    output logic              run,
    output logic              dis,
    output logic              action,
    output res_sel_e          sel,
    output logic [CNT_W-1:0]  preset,
    output logic              reload,
    output logic              fired,
    output logic              cause
);
    logic srst_n;
    logic wr_ctrl, wr_cnt, wr_cfg;

    assign srst_n  = rst_n & por_n;
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_cnt  = bus_wr && (bus_addr == OFS_CNT);
    assign wr_cfg  = bus_wr && (bus_addr == OFS_CFG);
    assign reload  = wr_ctrl && bus_wdata[CB_RELOAD];

    // Run bit: cannot be set while disabled; disabling clears it
    always_ff @(posedge clk) begin
        if (!srst_n)                           run <= 1'b0;
        else if (wr_cfg && bus_wdata[GB_DIS])  run <= 1'b0;
        else if (wr_ctrl)                      run <= bus_wdata[CB_RUN] & ~dis;
    end

    // Expiry action select
    always_ff @(posedge clk) begin
        if (!srst_n)      action <= 1'b0;
        else if (wr_ctrl) action <= bus_wdata[CB_ACTION];
    end

    // Sticky fired flag, set by expiry, cleared by writing one
    always_ff @(posedge clk) begin
        if (!srst_n)                                 fired <= 1'b0;
        else if (expire)                             fired <= 1'b1;
        else if (wr_ctrl && bus_wdata[CB_FIRED])     fired <= 1'b0;
    end

    // Configuration word: disable and resolution
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            dis <= 1'b1;
            sel <= RES_FINE;
        end else if (wr_cfg) begin
            dis <= bus_wdata[GB_DIS];
            sel <= res_sel_e'(bus_wdata[GB_RES_LO +: 2]);
        end
    end

    // Programmed timeout in ticks
    always_ff @(posedge clk) begin
        if (!srst_n)     preset <= '1;
        else if (wr_cnt) preset <= bus_wdata[CNT_W-1:0];
    end

    // Reset cause: cleared only at power-on
    always_ff @(posedge clk) begin
        if (!por_n)         cause <= 1'b0;
        else if (rst_pulse) cause <= 1'b1;
    end

    // Readback multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CB_RUN]    = run;
                bus_rdata[CB_FIRED]  = fired;
                bus_rdata[CB_ACTION] = action;
                bus_rdata[CB_DIS]    = dis;
            end
            OFS_CNT:  bus_rdata[CNT_W-1:0] = preset;
            OFS_CFG: begin
                bus_rdata[GB_DIS]         = dis;
                bus_rdata[GB_RES_LO +: 2] = sel;
            end
            OFS_STAT: bus_rdata[SB_CAUSE] = cause;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_top.sv
// Module wdt_top
// Watchdog timer: register file, tick prescaler and down-counter.
// The expiry pulse is routed to the reset or the shutdown request
// according to the action bit.
// Assumes rst_n is driven by the surrounding reset controller, which
// may itself be triggered by rst_req.
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIV_R0 = 32,
    parameter int DIV_R1 = 10000,
    parameter int DIV_R2 = 100000,
    parameter int DIV_R3 = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              off_req
);
    logic             srst_n;
    logic             run, dis, action, reload, fired, cause;
    logic             expire, halted, tick, active;
    res_sel_e         sel;
    logic [CNT_W-1:0] preset;

    assign srst_n  = rst_n & por_n;
    assign active  = run & ~dis & ~halted;
    assign rst_req = expire & ~action;
    assign off_req = expire & action;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .expire(expire), .rst_pulse(rst_req),
        .run(run), .dis(dis), .action(action), .sel(sel),
        .preset(preset), .reload(reload), .fired(fired), .cause(cause)
    );

    wdt_prescaler #(
        .DIV_R0(DIV_R0), .DIV_R1(DIV_R1), .DIV_R2(DIV_R2), .DIV_R3(DIV_R3)
    ) u_presc (
        .clk(clk), .srst_n(srst_n), .clr(reload | ~active),
        .sel(sel), .tick(tick)
    );

    wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .srst_n(srst_n), .reload(reload), .preset(preset),
        .count_en(active), .tick(tick), .expire(expire), .halted(halted)
    );
endmodule

// File: rtl/wdt_checker.sv
// Module wdt_checker
// Temporal properties of the watchdog, attached to wdt_top by bind.
// Assumes it sees the top-level ports and the register-file flags.
module wdt_checker (
    input logic clk,
    input logic rst_n,
    input logic por_n,
    input logic rst_req,
    input logic off_req,
    input logic run,
    input logic dis,
    input logic fired,
    input logic cause
);
    // R3 / R10: a request lasts one clock and is not repeated at once
    a_r3_one_clock: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        (rst_req || off_req) |=> !(rst_req || off_req));

    // R6: fired is set on the clock after any request
    a_r6_fired_follows: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        (rst_req || off_req) |=> fired);

    // R11: a reset request leaves the cause flag set
    a_r11_cause_set: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        rst_req |=> cause);

    // R11: only power-on reset may clear the cause flag
    a_r11_cause_kept: assert property (@(posedge clk) disable iff (!por_n)
        $past(cause) |-> cause);

    // R8: run is never set while the device is disabled
    a_r8_no_run: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        dis |-> !run);

    // R8: a device disabled for two clocks issues no request
    a_r8_silent: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        (dis && $past(dis)) |-> !(rst_req || off_req));
endmodule

bind wdt_top wdt_checker u_wdt_checker (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .rst_req(rst_req),
    .off_req(off_req), .run(run), .dis(dis), .fired(fired), .cause(cause)
);

// File: tb/wdt_top_bench.sv
module wdt_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int D0 = 2, D1 = 3, D2 = 4, D3 = 5;
    localparam int WD_CYCLES = 20000;
    // Row layout: [7:6] resolution, [5] action, [4:0] count
    localparam logic [7:0] VEC [8] = '{
        {2'd0, 1'b0, 5'd3}, {2'd1, 1'b0, 5'd2}, {2'd2, 1'b0, 5'd1},
        {2'd3, 1'b0, 5'd2}, {2'd0, 1'b0, 5'd0}, {2'd1, 1'b1, 5'd4},
        {2'd3, 1'b1, 5'd1}, {2'd2, 1'b0, 5'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b1, por_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, off_req;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    wdt_top #(.CNT_W(16), .DIV_R0(D0), .DIV_R1(D1), .DIV_R2(D2), .DIV_R3(D3))
    u_wdt_top (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .off_req(off_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int div_of(input logic [1:0] s);
        case (s)
            2'd0: return D0;
            2'd1: return D1;
            2'd2: return D2;
            default: return D3;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic do_por();
        por_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); por_n = 1'b1;
    endtask

    // Called at the falling edge after the reload write edge
    task automatic expect_fire(input int lat, input logic act, input string req);
        logic [31:0] d;
        repeat (lat - 1) @(posedge clk);
        @(negedge clk);
        check({req, " early"}, {30'd0, rst_req, off_req}, 32'd0);
        @(posedge clk); @(negedge clk);
        check({req, " due"}, {30'd0, rst_req, off_req}, {30'd0, ~act, act});
        rd(4'h0, d);
        check("R6 fired not yet", {31'd0, d[1]}, 32'd0);
        @(posedge clk); @(negedge clk);
        check({req, " width"}, {30'd0, rst_req, off_req}, 32'd0);
        rd(4'h0, d);
        check("R6 fired set", {31'd0, d[1]}, 32'd1);
    endtask

    task automatic watch_quiet(input int n, input string req);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
            if (rst_req || off_req) seen++;
        end
        check(req, seen, 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        do_por();
        // R1: reset values
        rd(4'h0, d); check("R1 ctrl", d, 32'h08);
        rd(4'h4, d); check("R1 count", d, 32'h0000FFFF);
        rd(4'h8, d); check("R1 cfg", d, 32'h01);
        rd(4'hC, d); check("R1 status", d, 32'h0);

        // R2 R3 R7: table of resolution, count and action
        for (int i = 0; i < 8; i++) begin
            logic [1:0] s; logic a; logic [4:0] n; int lat;
            s = VEC[i][7:6]; a = VEC[i][5]; n = VEC[i][4:0];
            do_por();
            wr(4'h8, {29'd0, s, 1'b0});
            wr(4'h4, {27'd0, n});
            wr(4'h0, 32'h83 | (32'(a) << 2));
            lat = ((n == 0) ? 1 : int'(n)) * div_of(s) + 1;
            expect_fire(lat, a, a ? "R7 R2 R3" : "R2 R3");
            rd(4'hC, d); check("R7 R11 cause", {31'd0, d[1]}, {31'd0, ~a});
        end

        // R12: run without reload starts nothing
        do_por();
        wr(4'h8, 32'h0); wr(4'h4, 32'd1); wr(4'h0, 32'h01);
        rd(4'h0, d); check("R12 run set", d, 32'h01);
        watch_quiet(40, "R12 no countdown");

        // R4: reload mid-count restarts the timeout
        do_por();
        wr(4'h8, 32'h0); wr(4'h4, 32'd4); wr(4'h0, 32'h81);
        repeat (5) @(posedge clk); @(negedge clk);
        wr(4'h0, 32'h81);
        expect_fire(9, 1'b0, "R4");

        // R9: stop freezes, resume continues
        do_por();
        wr(4'h8, 32'h0); wr(4'h4, 32'd3); wr(4'h0, 32'h81);
        repeat (3) @(posedge clk); @(negedge clk);
        wr(4'h0, 32'h00);
        watch_quiet(20, "R9 frozen");
        wr(4'h0, 32'h01);
        expect_fire(5, 1'b0, "R9 resume");

        // R10: halted after expiry, then R6 flag handling
        watch_quiet(30, "R10 halted");
        wr(4'h0, 32'h01);
        rd(4'h0, d); check("R6 write0 keeps", {31'd0, d[1]}, 32'd1);
        wr(4'h0, 32'h03);
        rd(4'h0, d); check("R6 write1 clears", {31'd0, d[1]}, 32'd0);
        wr(4'h4, 32'd1); wr(4'h0, 32'h81);
        expect_fire(3, 1'b0, "R10 rearm");

        // R11: cause survives functional reset, cleared by power-on
        rst_n = 1'b0;
        repeat (2) @(posedge clk); @(negedge clk); rst_n = 1'b1;
        rd(4'hC, d); check("R11 kept", d, 32'h2);
        rd(4'h0, d); check("R11 ctrl reset", d, 32'h08);
        do_por();
        rd(4'hC, d); check("R11 por clears", d, 32'h0);

        // R8: disabled device ignores run and stays silent
        wr(4'h4, 32'd1); wr(4'h0, 32'h81);
        rd(4'h0, d); check("R8 run ignored", d, 32'h08);
        watch_quiet(40, "R8 silent");
        wr(4'h8, 32'h0); wr(4'h4, 32'd5); wr(4'h0, 32'h81);
        repeat (2) @(posedge clk); @(negedge clk);
        wr(4'h8, 32'h1);
        rd(4'h0, d); check("R8 run cleared", d, 32'h08);
        watch_quiet(40, "R8 no expiry");

        // R5: readback masking
        do_por();
        wr(4'h8, 32'h0);
        wr(4'h0, 32'hF5);
        rd(4'h0, d); check("R5 ctrl mask", d, 32'h05);
        wr(4'h4, 32'hABCD1234);
        rd(4'h4, d); check("R5 count mask", d, 32'h00001234);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule